// File: doc/BRIEF.md
# Next Instruction Address Generator

This block owns the program counter of a single-cycle 32-bit load/store processor and decides, once per clock, where the next instruction is fetched from. Each cycle it presents the current address to instruction memory. It also presents that address plus one instruction (four bytes) for use elsewhere in the core.

The next address comes from one of three candidates: the sequential address, a PC-relative branch target or a region-relative jump target. Two chained selection stages pick between them. The first stage picks the branch target over the sequential address when the branch control bit and the ALU equality flag are both high. The second stage replaces that choice with the jump target when the jump control bit is high.

The PC register has two named conditions. In reset it holds the reset address. In run it loads the selected candidate on every rising edge, with no stall. Opcode decoding, the register file, the ALU and the memories are outside the block.

Top module: `npc_gen`

## Requirements
- R1: While `rst` is high at a rising edge, `pc_out` becomes 0x00000000 after that edge.
- R2: With `jmp_ctl`=0 and the branch condition false, the next `pc_out` is the current `pc_out` plus 4, wrapping modulo 2^32.
- R3: `pc_plus4` always equals `pc_out` plus 4, modulo 2^32.
- R4: With `jmp_ctl`=0, `br_ctl`=1 and `alu_eq_flag`=1, the next `pc_out` is computed as follows. Take `instr[15:0]` as a two's-complement count of instructions, multiply it by 4, and add it to `pc_plus4`.
- R5: With `br_ctl`=1 and `alu_eq_flag`=0, the branch is not taken and the next `pc_out` is the sequential address.
- R6: With `br_ctl`=0, `alu_eq_flag` has no effect and the next `pc_out` is the sequential address.
- R7: With `jmp_ctl`=1, the next `pc_out` is built by concatenation in three parts, from most to least significant. Bits 31..28 come from `pc_plus4` (not from the current `pc_out`). Bits 27..2 are `instr[25:0]`. Bits 1..0 are 00.
- R8: `jmp_ctl`=1 wins over a taken branch: with `br_ctl`=1 and `alu_eq_flag`=1 as well, the jump target is still loaded.
- R9: Bits 1..0 of `pc_out` are 00 in every cycle.
- R10: A negative branch immediate moves the PC backwards, including across address zero. For example, from 0x00000004 with immediate -3, the next PC is 0xFFFFFFFC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 32 | Instruction currently fetched |
| br_ctl | input | 1 | Conditional branch requested by decode |
| jmp_ctl | input | 1 | Unconditional jump requested by decode |
| alu_eq_flag | input | 1 | ALU result-is-zero flag |
| pc_out | output | 32 | Current instruction address |
| pc_plus4 | output | 32 | Current instruction address plus 4 |

## Verification
The clocked properties assume that `rst` is high at the first edge. They also assume that `instr`, `br_ctl`, `jmp_ctl` and `alu_eq_flag` carry known values at every rising edge, because each property relates the PC after an edge to those inputs before it. The bench holds reset from time zero and changes every input only on the falling clock edge. It takes random values for the instruction and the three control bits only after reset has released. Any combination of the control bits is legal, so the random phase needs no filtering.

// File: rtl/npc_pkg.sv
package npc_pkg;
    localparam int unsigned DEF_ADDR_W  = 32;
    localparam int unsigned DEF_INSTR_W = 32;
    localparam int unsigned DEF_IMM_W   = 16;
    localparam int unsigned DEF_JIDX_W  = 26;
    localparam int unsigned INSTR_BYTES = 4;
    localparam int unsigned ALIGN_BITS  = $clog2(INSTR_BYTES);

    typedef enum logic {
        PC_RESET = 1'b0,
        PC_RUN   = 1'b1
    } pc_mode_e;
endpackage

// File: rtl/npc_incr.sv
module npc_incr #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned STEP   = 4
) (
    input  logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] seq_addr
);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    always_comb begin
        seq_addr = cur_addr + STEP_V;
    end
endmodule

// File: rtl/npc_branch_tgt.sv
module npc_branch_tgt #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IMM_W  = 16,
    parameter int unsigned ALIGN  = 2
) (
    input  logic [ADDR_W-1:0] seq_addr,
    input  logic [IMM_W-1:0]  imm,
    output logic [ADDR_W-1:0] br_addr
);
    localparam int unsigned EXT_W = ADDR_W - IMM_W - ALIGN;

    logic [ADDR_W-1:0] byte_ofs;

    always_comb begin
        byte_ofs = {{EXT_W{imm[IMM_W-1]}}, imm, {ALIGN{1'b0}}};
        br_addr  = seq_addr + byte_ofs;
    end
endmodule

// File: rtl/npc_jump_tgt.sv
module npc_jump_tgt #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IDX_W  = 26,
    parameter int unsigned ALIGN  = 2,
    localparam int unsigned TOP_W = ADDR_W - IDX_W - ALIGN
) (
    input  logic [TOP_W-1:0]  region,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] jmp_addr
);
    always_comb begin
        jmp_addr = {region, idx, {ALIGN{1'b0}}};
    end
endmodule

// File: rtl/npc_select.sv
module npc_select #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] seq_addr,
    input  logic [ADDR_W-1:0] br_addr,
    input  logic [ADDR_W-1:0] jmp_addr,
    input  logic              br_ctl,
    input  logic              alu_eq_flag,
    input  logic              jmp_ctl,
    output logic [ADDR_W-1:0] next_addr
);
    logic              take_br;
    logic [ADDR_W-1:0] stage1;

    always_comb begin
        take_br = br_ctl & alu_eq_flag;
        unique case (take_br)
            1'b1:    stage1 = br_addr;
            default: stage1 = seq_addr;
        endcase
        unique case (jmp_ctl)
            1'b1:    next_addr = jmp_addr;
            default: next_addr = stage1;
        endcase
    end
endmodule

// File: rtl/npc_gen.sv
module npc_gen #(
    parameter int unsigned           ADDR_W   = npc_pkg::DEF_ADDR_W,
    parameter int unsigned           INSTR_W  = npc_pkg::DEF_INSTR_W,
    parameter int unsigned           IMM_W    = npc_pkg::DEF_IMM_W,
    parameter int unsigned           JIDX_W   = npc_pkg::DEF_JIDX_W,
    parameter logic [ADDR_W-1:0]     RESET_PC = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [INSTR_W-1:0] instr,
    input  logic               br_ctl,
    input  logic               jmp_ctl,
    input  logic               alu_eq_flag,
    output logic [ADDR_W-1:0]  pc_out,
    output logic [ADDR_W-1:0]  pc_plus4
);
    import npc_pkg::*;

    localparam int unsigned ALIGN = ALIGN_BITS;
    localparam int unsigned TOP_W = ADDR_W - JIDX_W - ALIGN;

    pc_mode_e          mode;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] seq_addr;
    logic [ADDR_W-1:0] br_addr;
    logic [ADDR_W-1:0] jmp_addr;
    logic [ADDR_W-1:0] next_addr;
    logic              unused_opcode_bits;

    assign unused_opcode_bits = ^instr[INSTR_W-1:JIDX_W];
    assign mode = rst ? PC_RESET : PC_RUN;

    npc_incr #(.ADDR_W(ADDR_W), .STEP(INSTR_BYTES)) u_incr (
        .cur_addr (pc_q),
        .seq_addr (seq_addr)
    );

    npc_branch_tgt #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .ALIGN(ALIGN)) u_br (
        .seq_addr (seq_addr),
        .imm      (instr[IMM_W-1:0]),
        .br_addr  (br_addr)
    );

    npc_jump_tgt #(.ADDR_W(ADDR_W), .IDX_W(JIDX_W), .ALIGN(ALIGN)) u_jmp (
        .region   (seq_addr[ADDR_W-1 -: TOP_W]),
        .idx      (instr[JIDX_W-1:0]),
        .jmp_addr (jmp_addr)
    );

    npc_select #(.ADDR_W(ADDR_W)) u_sel (
        .seq_addr    (seq_addr),
        .br_addr     (br_addr),
        .jmp_addr    (jmp_addr),
        .br_ctl      (br_ctl),
        .alu_eq_flag (alu_eq_flag),
        .jmp_ctl     (jmp_ctl),
        .next_addr   (next_addr)
    );

    always_ff @(posedge clk) begin
        unique case (mode)
            PC_RESET: pc_q <= RESET_PC;
            PC_RUN:   pc_q <= next_addr;
        endcase
    end

    always_comb begin
        pc_out   = pc_q;
        pc_plus4 = seq_addr;
    end

    AST_RESET_LOAD: assert property (@(posedge clk)
        rst |=> pc_out == RESET_PC); // R1

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (!jmp_ctl && !(br_ctl && alu_eq_flag)) |=> pc_out == $past(pc_plus4)); // R2

    AST_PLUS4_LINK: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> pc_plus4 - pc_out == ADDR_W'(INSTR_BYTES)); // R3

    AST_JUMP_WINS: assert property (@(posedge clk) disable iff (rst)
        jmp_ctl |=> pc_out[ADDR_W-TOP_W-1:ALIGN] == $past(instr[JIDX_W-1:0])); // R8

    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> pc_out[ALIGN-1:0] == '0); // R9
endmodule

// File: tb/npc_gen_tb.sv
module npc_gen_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr = '0;
    logic        br_ctl = 1'b0;
    logic        jmp_ctl = 1'b0;
    logic        alu_eq_flag = 1'b0;
    logic [31:0] pc_out;
    logic [31:0] pc_plus4;

    int          errors = 0;
    int          checks = 0;
    logic [31:0] model_pc = '0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    npc_gen u_dut (
        .clk         (clk),
        .rst         (rst),
        .instr       (instr),
        .br_ctl      (br_ctl),
        .jmp_ctl     (jmp_ctl),
        .alu_eq_flag (alu_eq_flag),
        .pc_out      (pc_out),
        .pc_plus4    (pc_plus4)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_next(input logic [31:0] pc, input logic [31:0] ins,
                                             input logic br, input logic jm, input logic z);
        longint seq, off;
        seq = (longint'(pc) + 4) % 64'h1_0000_0000;
        if (jm)
            return (32'(seq) & 32'hF000_0000) | ((ins & 32'h03FF_FFFF) * 4);
        if (br && z) begin
            off = longint'($signed(ins[15:0])) * 4;
            return 32'(seq + off);
        end
        return 32'(seq);
    endfunction

    task automatic step(input string req, input logic [31:0] ins,
                        input logic br, input logic jm, input logic z);
        logic [31:0] exp;
        instr = ins; br_ctl = br; jmp_ctl = jm; alu_eq_flag = z;
        exp = ref_next(model_pc, ins, br, jm, z);
        @(posedge clk);
        @(negedge clk);
        model_pc = exp;
        check(req, pc_out, exp);
        check("R3", pc_plus4, exp + 32'd4);
        check("R9", {30'd0, pc_out[1:0]}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        check("R1", pc_out, 32'h0);
        rst = 1'b0;
        model_pc = '0;
        // R2 sequential
        step("R2", 32'h0000_0000, 1'b0, 1'b0, 1'b0);
        step("R2", 32'h1234_5678, 1'b0, 1'b0, 1'b0);
        // R4 taken branch, +3 instructions: 0x8 -> 0xC+0xC = 0x18
        step("R4", 32'h0000_0003, 1'b1, 1'b0, 1'b1);
        check("R4", pc_out, 32'h0000_0018);
        // R5 branch requested, flag low
        step("R5", 32'h0000_0040, 1'b1, 1'b0, 1'b0);
        check("R5", pc_out, 32'h0000_001C);
        // R6 flag high without branch request
        step("R6", 32'h0000_0040, 1'b0, 1'b0, 1'b1);
        check("R6", pc_out, 32'h0000_0020);
        // R10 backward branch -2: 0x20 -> 0x24-8 = 0x1C
        step("R10", 32'h0000_FFFE, 1'b1, 1'b0, 1'b1);
        check("R10", pc_out, 32'h0000_001C);
        // R10 across zero: reach 0x4 then -3
        step("R7", 32'h0000_0001, 1'b0, 1'b1, 1'b0);
        check("R7", pc_out, 32'h0000_0004);
        step("R10", 32'h0000_FFFD, 1'b1, 1'b0, 1'b1);
        check("R10", pc_out, 32'hFFFF_FFFC);
        // R2 wrap to zero
        step("R2", 32'h0, 1'b0, 1'b0, 1'b0);
        check("R2", pc_out, 32'h0000_0000);
        // R7 jump to top of first region, then upper bits from PC+4
        step("R7", 32'h03FF_FFFF, 1'b0, 1'b1, 1'b0);
        check("R7", pc_out, 32'h0FFF_FFFC);
        step("R7", 32'h0000_0005, 1'b0, 1'b1, 1'b0);
        check("R7", pc_out, 32'h1000_0014);
        // R8 jump over taken branch
        step("R8", 32'h0000_0010, 1'b1, 1'b1, 1'b1);
        check("R8", pc_out, 32'h1000_0040);
        // R1 reset in mid-run
        @(negedge clk); rst = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R1", pc_out, 32'h0);
        rst = 1'b0;
        model_pc = '0;
        for (int i = 0; i < 300; i++) begin
            step("R2/R4/R7", $urandom, 1'($urandom), 1'($urandom_range(0, 3) == 0), 1'($urandom));
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule